// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the moment at which a chosen kind of event occurs on an input pin. It watches the pin through a synchronizer and detects its edges. A programmable qualifier decides which edges count. When a qualifying event arrives, the block copies the value of one of two external 16-bit free-running timers into a capture register and raises an interrupt flag.

Software sets the block up through a small register port. One field selects the event kind: falling edge, rising edge, every fourth rising edge or every sixteenth rising edge. A separate select input chooses which of the two timebases is sampled. Software reads the captured time as two bytes and clears the flag by writing to it. The edge detector follows the real pin level, so a transition that the chip itself drives onto the pin is captured like an external one.

Top module: `evt_capture`

## Requirements
- R1: After reset, the capture register reads 0 at addresses 0 and 1, the control register at address 2 reads 0, the flag register at address 3 reads 0, and `cap_irq` is 0.
- R2: The pin passes through a two-flop synchronizer and a registered edge detector. A pin change sampled at rising clock edge E0 updates the capture register and the flag at edge E0+3. The value latched is the timer value present in the clock cycle that ends at that edge, and the flag is still 0 after edge E0+2.
- R3: With mode field (address 2, bits 3:0) equal to 4'b0100, every falling pin edge captures and rising edges are ignored.
- R4: With mode 4'b0101, every rising pin edge captures and falling edges are ignored.
- R5: With mode 4'b0110, only every 4th rising edge captures, counted from the last mode write or the last capture.
- R6: With mode 4'b0111, only every 16th rising edge captures.
- R7: Any other mode value disables capture: pin edges change neither the capture register nor the flag.
- R8: `tb_sel` = 0 samples `timer_a` and `tb_sel` = 1 samples `timer_b`.
- R9: A capture sets the flag (address 3, bit 0, also on `cap_irq`). The flag stays set until software writes a value with bit 0 equal to 0 to address 3. Writing bit 0 = 1 leaves it as it is. When a capture and a clearing write fall in the same cycle, the flag stays set.
- R10: A new capture overwrites an unread earlier value.
- R11: Any write to the mode field resets the prescale count to zero, even when the value written is unchanged.
- R12: The capture register is readable and writable as a low byte at address 0 and a high byte at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap_pin | input | 1 | Pin level that is watched for events |
| tb_sel | input | 1 | Timebase select: 0 selects timer_a, 1 selects timer_b |
| timer_a | input | 16 | First free-running timebase |
| timer_b | input | 16 | Second free-running timebase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 flag |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` (combinational) |
| cap_irq | output | 1 | Interrupt flag |

## Verification
Each mode is driven with alternating rising and falling pin edges. This shows that the edge selection follows the mode and that the prescaler fires on exactly the 4th or 16th rising edge, and on no edge before it. The bench drives the timebases with a counter that changes every cycle, so an off-by-one in capture latency shows up as a wrong captured value. The two timers never hold equal values, which makes the selected timebase visible. Mode rewrites part-way through a count, back-to-back captures, disabled encodings and a clearing write in the same cycle as a capture tell apart the counter reset, the overwrite and the flag priority rules.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF    = 4'b0000,
    CM_FALL   = 4'b0100,
    CM_RISE   = 4'b0101,
    CM_RISE4  = 4'b0110,
    CM_RISE16 = 4'b0111
  } cap_mode_e;

  localparam int unsigned DIV_A_LOG2 = 2;
  localparam int unsigned DIV_B_LOG2 = 4;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == CM_FALL) || (m == CM_RISE) || (m == CM_RISE4) || (m == CM_RISE16);
  endfunction
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] shift_q, shift_d;
  logic              last_q;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic              synced;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], pin_i};
    synced  = shift_q[STAGES-1];
    rise_d  = synced & ~last_q;
    fall_d  = ~synced & last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      last_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      last_q  <= synced;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/ecap_qual.sv
module ecap_qual
  import evt_capture_pkg::*;
#(
  parameter int unsigned PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mode_wr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              fire_o
);
  localparam logic [PRE_W-1:0] LAST_A = PRE_W'((1 << DIV_A_LOG2) - 1);
  localparam logic [PRE_W-1:0] LAST_B = PRE_W'((1 << DIV_B_LOG2) - 1);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fire;

  always_comb begin
    fire  = 1'b0;
    cnt_d = cnt_q;
    unique case (mode_i)
      CM_FALL: fire = fall_i;
      CM_RISE: fire = rise_i;
      CM_RISE4: begin
        if (rise_i) begin
          if (cnt_q == LAST_A) begin
            fire  = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      CM_RISE16: begin
        if (rise_i) begin
          if (cnt_q == LAST_B) begin
            fire  = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: cnt_d = '0;
    endcase
    if (mode_wr_i) cnt_d = '0;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fire_o = fire;
endmodule

// File: rtl/ecap_regs.sv
module ecap_regs
  import evt_capture_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              tb_sel_i,
  input  logic [TW-1:0]     timer_a_i,
  input  logic [TW-1:0]     timer_b_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BW-1:0]     wr_data_i,
  output logic [BW-1:0]     rd_data_o,
  output logic              irq_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_wr_o,
  output logic [TW-1:0]     cap_o
);
  localparam int unsigned NB        = TW / BW;
  localparam int unsigned CTRL_ADDR = NB;
  localparam int unsigned FLAG_ADDR = NB + 1;

  logic [TW-1:0]     cap_q, cap_d, sample;
  logic              cap_en;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_wr;
  logic              flag_q, flag_d, flag_clr, flag_en;
  logic [NB-1:0]     byte_wr;

  for (genvar g = 0; g < NB; g++) begin : g_bsel
    assign byte_wr[g] = wr_en_i && (addr_i == AW'(g));
  end

  always_comb begin
    sample = tb_sel_i ? timer_b_i : timer_a_i;
    cap_d  = cap_q;
    for (int i = 0; i < NB; i++) begin
      if (byte_wr[i]) cap_d[i*BW +: BW] = wr_data_i;
    end
    if (fire_i) cap_d = sample;
    cap_en = fire_i | (|byte_wr);
  end

  always_comb begin
    mode_wr = wr_en_i && (addr_i == AW'(CTRL_ADDR));
    mode_d  = mode_wr ? wr_data_i[MODE_W-1:0] : mode_q;
  end

  always_comb begin
    flag_clr = wr_en_i && (addr_i == AW'(FLAG_ADDR)) && !wr_data_i[0];
    flag_d   = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (fire_i)   flag_d = 1'b1;
    flag_en  = fire_i | flag_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == AW'(i)) rd_data_o = cap_q[i*BW +: BW];
    end
    if (addr_i == AW'(CTRL_ADDR)) rd_data_o = {{(BW-MODE_W){1'b0}}, mode_q};
    if (addr_i == AW'(FLAG_ADDR)) rd_data_o = {{(BW-1){1'b0}}, flag_q};
  end

  assign irq_o     = flag_q;
  assign mode_o    = mode_q;
  assign mode_wr_o = mode_wr;
  assign cap_o     = cap_q;
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_capture_pkg::*;
#(
  parameter int unsigned TIMER_W     = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_W       = 4,
  localparam int unsigned ADDR_W     = $clog2(TIMER_W / BYTE_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_pin,
  input  logic               tb_sel,
  input  logic [TIMER_W-1:0] timer_a,
  input  logic [TIMER_W-1:0] timer_b,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               cap_irq
);
  logic              edge_rise, edge_fall;
  logic              cap_fire;
  logic [MODE_W-1:0] mode_q;
  logic              mode_wr;
  logic [TIMER_W-1:0] cap_value;

  ecap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  ecap_qual #(.PRE_W(PRE_W)) qual_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_q),
    .mode_wr_i (mode_wr),
    .rise_i    (edge_rise),
    .fall_i    (edge_fall),
    .fire_o    (cap_fire)
  );

  ecap_regs #(.TW(TIMER_W), .BW(BYTE_W), .AW(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (cap_fire),
    .tb_sel_i  (tb_sel),
    .timer_a_i (timer_a),
    .timer_b_i (timer_b),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (cap_irq),
    .mode_o    (mode_q),
    .mode_wr_o (mode_wr),
    .cap_o     (cap_value)
  );
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk
  import evt_capture_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tb_sel,
  input logic [TIMER_W-1:0] timer_a,
  input logic [TIMER_W-1:0] timer_b,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [BYTE_W-1:0]  wr_data,
  input logic               cap_irq,
  input logic               cap_fire,
  input logic               edge_rise,
  input logic               edge_fall,
  input logic [MODE_W-1:0]  mode_q,
  input logic [TIMER_W-1:0] cap_value
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(TIMER_W / BYTE_W + 1);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_irq);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_irq && !(wr_en && addr == FLAG_A && !wr_data[0])) |=> cap_irq);

  // R8
  sample_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_value == $past(tb_sel ? timer_b : timer_a));

  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active(mode_q) |-> !cap_fire);

  // R2
  fire_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> (edge_rise || edge_fall));

  // R3
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && mode_q == CM_FALL) |-> edge_fall);

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !wr_en) |=> $stable(cap_value));
endmodule

bind evt_capture evt_capture_chk #(
  .TIMER_W (TIMER_W),
  .BYTE_W  (BYTE_W),
  .ADDR_W  (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_sel    (tb_sel),
  .timer_a   (timer_a),
  .timer_b   (timer_b),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .cap_irq   (cap_irq),
  .cap_fire  (cap_fire),
  .edge_rise (edge_rise),
  .edge_fall (edge_fall),
  .mode_q    (mode_q),
  .cap_value (cap_value)
);

// File: tb/evt_capture_tb_top.sv
module evt_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cap_pin;
  logic        tb_sel;
  logic [15:0] timer_a;
  logic [15:0] timer_b;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        cap_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  evt_capture dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_pin (cap_pin),
    .tb_sel  (tb_sel),
    .timer_a (timer_a),
    .timer_b (timer_b),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cap_irq (cap_irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial timer_a = 16'h0100;
  always @(negedge clk) timer_a <= timer_a + 16'd1;
  assign timer_b = timer_a ^ 16'hA5C3;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic rd_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_mode(input logic [3:0] m, input logic sel);
    tb_sel = sel;
    wr(2'd2, {4'b0000, m});
  endtask

  task automatic clr_flag();
    wr(2'd3, 8'h00);
  endtask

  // drive pin, return flag after third edge and timer at fourth edge
  task automatic pin_edge(input logic v, output logic early, output logic [15:0] exp);
    @(negedge clk);
    cap_pin = v;
    repeat (3) @(posedge clk);
    #1 early = cap_irq;
    @(posedge clk);
    exp = tb_sel ? timer_b : timer_a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] c; logic [7:0] v;
    rd_cap(c);
    chk(c == 16'h0000, "R1 capture after reset", c, 16'h0000);
    rd(2'd2, v);
    chk(v == 8'h00, "R1 control after reset", {8'h00, v}, 16'h0000);
    rd(2'd3, v);
    chk(v == 8'h00 && !cap_irq, "R1 flag after reset", {8'h00, v}, 16'h0000);
  endtask

  task automatic t_rise_latency();
    logic e; logic [15:0] x, c, prev;
    set_mode(4'b0101, 1'b0);
    pin_edge(1'b1, e, x);
    chk(!e, "R2 flag still clear after third edge", {15'd0, e}, 16'd0);
    chk(cap_irq, "R4 rising edge sets flag", {15'd0, cap_irq}, 16'd1);
    rd_cap(c);
    chk(c == x, "R2 timer value at fourth edge", c, x);
    prev = c;
    clr_flag();
    pin_edge(1'b0, e, x);
    rd_cap(c);
    chk(!cap_irq && c == prev, "R4 falling edge ignored", c, prev);
  endtask

  task automatic t_fall();
    logic e; logic [15:0] x, c, prev;
    set_mode(4'b0100, 1'b0);
    clr_flag();
    rd_cap(prev);
    pin_edge(1'b1, e, x);
    rd_cap(c);
    chk(!cap_irq && c == prev, "R3 rising edge ignored", c, prev);
    pin_edge(1'b0, e, x);
    rd_cap(c);
    chk(cap_irq && c == x, "R3 falling edge captures", c, x);
    clr_flag();
  endtask

  task automatic t_div(input logic [3:0] m, input int n, input string req);
    logic e; logic [15:0] x, c;
    int early_hits;
    set_mode(m, 1'b0);
    clr_flag();
    for (int round = 0; round < 2; round++) begin
      early_hits = 0;
      for (int k = 1; k <= n; k++) begin
        pin_edge(1'b1, e, x);
        if (k < n && cap_irq) early_hits++;
        if (k == n) begin
          rd_cap(c);
          chk(cap_irq && c == x, req, c, x);
        end
        pin_edge(1'b0, e, x);
      end
      chk(early_hits == 0, req, 16'(early_hits), 16'd0);
      clr_flag();
    end
  endtask

  task automatic t_disabled();
    logic e; logic [15:0] x, c, prev;
    logic [3:0] modes [4];
    modes[0] = 4'b0000; modes[1] = 4'b0011; modes[2] = 4'b1000; modes[3] = 4'b1111;
    clr_flag();
    rd_cap(prev);
    for (int i = 0; i < 4; i++) begin
      set_mode(modes[i], 1'b0);
      pin_edge(1'b1, e, x);
      pin_edge(1'b0, e, x);
      rd_cap(c);
      chk(!cap_irq && c == prev, "R7 disabled mode no capture", c, prev);
    end
  endtask

  task automatic t_tbsel();
    logic e; logic [15:0] x, c;
    set_mode(4'b0101, 1'b1);
    clr_flag();
    pin_edge(1'b1, e, x);
    rd_cap(c);
    chk(c == x && c == (timer_a ^ 16'hA5C3) - 16'h0 || c == x, "R8 timer_b sampled", c, x);
    pin_edge(1'b0, e, x);
    tb_sel = 1'b0;
    pin_edge(1'b1, e, x);
    rd_cap(c);
    chk(c == x, "R8 timer_a sampled", c, x);
    pin_edge(1'b0, e, x);
  endtask

  task automatic t_flag();
    logic e; logic [15:0] x;
    set_mode(4'b0101, 1'b0);
    clr_flag();
    pin_edge(1'b1, e, x);
    repeat (5) @(negedge clk);
    chk(cap_irq, "R9 flag holds", {15'd0, cap_irq}, 16'd1);
    wr(2'd3, 8'h01);
    chk(cap_irq, "R9 write of one keeps flag", {15'd0, cap_irq}, 16'd1);
    clr_flag();
    chk(!cap_irq, "R9 write of zero clears flag", {15'd0, cap_irq}, 16'd0);
    pin_edge(1'b0, e, x);
    // clearing write in the capture cycle
    @(negedge clk);
    cap_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk(cap_irq, "R9 capture beats clear", {15'd0, cap_irq}, 16'd1);
    pin_edge(1'b0, e, x);
    clr_flag();
  endtask

  task automatic t_overwrite();
    logic e; logic [15:0] x1, x2, c;
    set_mode(4'b0101, 1'b0);
    clr_flag();
    pin_edge(1'b1, e, x1);
    pin_edge(1'b0, e, x2);
    pin_edge(1'b1, e, x2);
    rd_cap(c);
    chk(c == x2 && x2 != x1, "R10 second capture overwrites", c, x2);
    pin_edge(1'b0, e, x2);
    clr_flag();
  endtask

  task automatic t_mode_rewrite();
    logic e; logic [15:0] x;
    int hits;
    set_mode(4'b0110, 1'b0);
    clr_flag();
    for (int k = 0; k < 2; k++) begin
      pin_edge(1'b1, e, x);
      pin_edge(1'b0, e, x);
    end
    set_mode(4'b0110, 1'b0);
    hits = 0;
    for (int k = 0; k < 3; k++) begin
      pin_edge(1'b1, e, x);
      if (cap_irq) hits++;
      pin_edge(1'b0, e, x);
    end
    chk(hits == 0, "R11 count restarts on mode write", 16'(hits), 16'd0);
    pin_edge(1'b1, e, x);
    chk(cap_irq, "R11 fourth edge after rewrite captures", {15'd0, cap_irq}, 16'd1);
    pin_edge(1'b0, e, x);
    clr_flag();
  endtask

  task automatic t_bytes();
    logic [15:0] c;
    set_mode(4'b0000, 1'b0);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    rd_cap(c);
    chk(c == 16'h1234, "R12 byte write and read", c, 16'h1234);
    wr(2'd0, 8'hCD);
    rd_cap(c);
    chk(c == 16'h12CD, "R12 low byte alone", c, 16'h12CD);
  endtask

  initial begin
    rst_n = 1'b0; cap_pin = 1'b0; tb_sel = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rise_latency();
    t_fall();
    t_div(4'b0110, 4, "R5 every 4th rising edge");
    t_div(4'b0111, 16, "R6 every 16th rising edge");
    t_disabled();
    t_tbsel();
    t_flag();
    t_overwrite();
    t_mode_rewrite();
    t_bytes();
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
      wait (done);
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule